// File: doc/BRIEF.md
# Two-Requester Line Fetch Merger with Process-Based Return Fan-Out

This block lets two cooperating processing chips share one memory read channel for whole cache lines. Each chip presents read requests that carry a line address and a process identifier. The block merges the two request streams onto a single outgoing channel. The two chips take turns in strict alternation. When the chip that holds the turn has nothing to send, the other chip may use the slot.

The request side never waits for read data. Any number of requests, up to the depth of an internal pending table, may be in flight. Responses come back after an unknown latency and in any order. Every response beat carries the line address and the process identifier. The block uses that pair as the tag to find the matching pending entry.

The returned beats are fanned out on a shared data bus, with one valid/ready pair per chip. A chip receives a beat when its local process roster holds the beat's process identifier. The chip that issued the request always receives the beat as well. A beat is consumed from the memory side only once every chip it was sent to has taken it. Beats whose tag matches no pending entry are discarded, and a sticky error output is raised.

Top module: `duo_line_fetch`

## Requirements
- R1: When both chips request in consecutive accepted slots, the accepted chip alternates, starting with chip 0 after reset. At most one `req_ready` bit is high in any cycle.
- R2: If the chip holding the turn has no request, the other chip's request is accepted in that slot. The following contested slot then goes to the chip that skipped.
- R3: `mem_req_valid` is high whenever some chip requests and the table is not full, regardless of response traffic. `mem_req_addr`/`mem_req_pid` are the granted chip's values. A request is accepted exactly when `mem_req_valid` and `mem_req_ready` are both high.
- R4: While `OUTSTANDING` lines are pending, `mem_req_valid` and both `req_ready` bits stay low.
- R5: A response beat is matched to the pending entry with equal address and process identifier, independent of issue order. `dlv_data`, `dlv_addr`, `dlv_pid` and `dlv_last` copy the response beat.
- R6: `dlv_valid[c]` is raised for a matched beat when chip c's roster holds the beat's process identifier.
- R7: The chip recorded as the requester of the line receives every beat of the line, even when its roster lacks the identifier.
- R8: `rsp_ready` for a matched beat is high only when every targeted chip has accepted the beat, in this cycle or earlier. A chip that has accepted a beat sees its `dlv_valid` low until the beat retires.
- R9: A pending entry stays live across beats with `rsp_last`=0 and is freed when the beat with `rsp_last`=1 retires. A later beat with the same tag is unmatched.
- R10: An unmatched beat is consumed at once (`rsp_ready`=1), raises no `dlv_valid`, and sets `tag_err` from the next cycle until reset.
- R11: A roster write with `cfg_set`=1 stores `cfg_pid` in slot `cfg_idx` of chip `cfg_chip`. A write with `cfg_set`=0 empties that slot, and chip `cfg_chip` stops receiving lines by that identifier unless it is the line's requester.
- R12: After reset, `req_ready`, `mem_req_valid`, `dlv_valid` and `tag_err` are all low, no line is pending, and every roster slot is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 2 | Per-chip request present |
| req_ready | output | 2 | Per-chip request accepted this cycle |
| req_addr | input | 2 x AW | Per-chip line address |
| req_pid | input | 2 x PW | Per-chip process identifier |
| mem_req_valid | output | 1 | Merged request present |
| mem_req_ready | input | 1 | Memory side takes the merged request |
| mem_req_addr | output | AW | Merged request line address |
| mem_req_pid | output | PW | Merged request process identifier |
| rsp_valid | input | 1 | Response beat present |
| rsp_ready | output | 1 | Response beat consumed |
| rsp_addr | input | AW | Line address tag of the beat |
| rsp_pid | input | PW | Process identifier tag of the beat |
| rsp_data | input | DW | Beat payload |
| rsp_last | input | 1 | Final beat of the line |
| dlv_valid | output | 2 | Per-chip delivery valid |
| dlv_ready | input | 2 | Per-chip delivery accepted |
| dlv_data | output | DW | Delivered payload |
| dlv_addr | output | AW | Delivered line address |
| dlv_pid | output | PW | Delivered process identifier |
| dlv_last | output | 1 | Delivered beat is the last of its line |
| cfg_we | input | 1 | Roster write strobe |
| cfg_chip | input | 1 | Roster select (0 or 1) |
| cfg_idx | input | clog2(ROSTER_DEPTH) | Roster slot |
| cfg_pid | input | PW | Identifier to store |
| cfg_set | input | 1 | 1 stores and validates the slot, 0 empties it |
| tag_err | output | 1 | Sticky unmatched-response flag |

## Verification
The bench builds the block with AW=16, PW=4, DW=32, OUTSTANDING=4 and ROSTER_DEPTH=2. With a four-entry table, two rounds of paired requests fill it, so the blocked-while-full behaviour appears within a few cycles. Responses can then be returned in an order opposite to issue. A two-slot roster lets the test reach both the case where both chips are registered and the case where only the requester is served, and a clear of a live slot can be observed at the delivery ports. An alternating ready pattern on the two delivery ports makes one chip accept a beat cycles before the other, which exercises the partial-acceptance bookkeeping.

// File: rtl/duo_pkg.sv
// Shared definitions for the two-requester line fetch merger.
// Assumes exactly two requesting chips; everything else is parameterised
// in the modules that import this package.
package duo_pkg;
    localparam int CHIPS = 2;
    typedef logic [CHIPS-1:0] chip_mask_t;
endpackage

// File: rtl/turn_arbiter.sv
// Alternating-turn arbiter for two requesters.
// The turn holder wins when it requests; otherwise the other side may take
// the slot. The turn moves to the loser only when a request is accepted,
// so a skipped turn stays with the chip that skipped it.
// Assumes `go` already folds in downstream readiness and table capacity.
module turn_arbiter
    import duo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  chip_mask_t want,
    input  logic       go,
    output chip_mask_t grant,
    output logic       pick,
    output logic       any
);
    logic turn;

    // choose the turn holder if it asks, else the other chip
    always_comb begin
        pick  = want[turn] ? turn : ~turn;
        any   = |want;
        grant = (go && any) ? (chip_mask_t'(1) << pick) : '0;
    end

    // hand the turn to the chip that did not win an accepted slot
    always_ff @(posedge clk) begin
        if (!rst_n)      turn <= 1'b0;
        else if (|grant) turn <= ~pick;
    end

    // R1
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // R1
    alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&want && |grant) |=> !(&want && |grant && grant == $past(grant)));
    // R2
    skip_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && $onehot(want)) |-> (grant == want));
endmodule

// File: rtl/pid_roster.sv
// Per-chip roster of process identifiers that the chip is running.
// A host write stores an identifier in a slot and marks it valid, or empties
// the slot. The query port reports whether any valid slot holds q_pid.
// Assumes write index values at or above DEPTH are ignored.
module pid_roster #(
    parameter int PW    = 8,
    parameter int DEPTH = 8,
    parameter int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [PW-1:0] wr_pid,
    input  logic          wr_set,
    input  logic [PW-1:0] q_pid,
    output logic          q_hit
);
    logic [DEPTH-1:0]         slot_v;
    logic [DEPTH-1:0][PW-1:0] slot_pid;
    logic [DEPTH-1:0]         slot_hit;

    // slot valid flags: set or cleared by host writes
    always_ff @(posedge clk) begin
        if (!rst_n)
            slot_v <= '0;
        else if (wr_en && (int'(wr_idx) < DEPTH))
            slot_v[wr_idx] <= wr_set;
    end

    // slot identifiers: captured only on a set write
    always_ff @(posedge clk) begin
        if (wr_en && wr_set && (int'(wr_idx) < DEPTH))
            slot_pid[wr_idx] <= wr_pid;
    end

    // compare every slot against the queried identifier
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign slot_hit[g] = slot_v[g] && (slot_pid[g] == q_pid);
    end

    assign q_hit = |slot_hit;

    // R11
    set_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_set && (int'(wr_idx) < DEPTH)) |=> (q_pid != $past(wr_pid) || q_hit));
endmodule

// File: rtl/pending_table.sv
// Table of read lines sent to memory and not yet fully returned.
// Allocation takes the lowest free slot. Lookup finds the lowest valid slot
// whose address and identifier both match. Freeing clears the looked-up slot.
// Assumes the caller never allocates while full and frees only on a hit.
module pending_table #(
    parameter int AW    = 32,
    parameter int PW    = 8,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_en,
    input  logic [AW-1:0] alloc_addr,
    input  logic [PW-1:0] alloc_pid,
    input  logic          alloc_who,
    output logic          full,
    input  logic [AW-1:0] look_addr,
    input  logic [PW-1:0] look_pid,
    output logic          look_hit,
    output logic          look_who,
    input  logic          free_en
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0]         vld;
    logic [DEPTH-1:0][AW-1:0] ent_addr;
    logic [DEPTH-1:0][PW-1:0] ent_pid;
    logic [DEPTH-1:0]         ent_who;
    logic [DEPTH-1:0]         match;
    logic [IW-1:0]            free_slot;
    logic [IW-1:0]            hit_slot;

    // tag comparison for every slot
    for (genvar g = 0; g < DEPTH; g++) begin : g_match
        assign match[g] = vld[g] && (ent_addr[g] == look_addr) && (ent_pid[g] == look_pid);
    end

    // lowest free slot and lowest matching slot
    always_comb begin
        free_slot = '0;
        hit_slot  = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!vld[i])  free_slot = IW'(i);
            if (match[i]) hit_slot  = IW'(i);
        end
    end

    assign full     = &vld;
    assign look_hit = |match;
    assign look_who = ent_who[hit_slot];

    // slot occupancy: allocate and free
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
        end else begin
            if (free_en && look_hit) vld[hit_slot]  <= 1'b0;
            if (alloc_en)            vld[free_slot] <= 1'b1;
        end
    end

    // slot payload: written on allocation
    always_ff @(posedge clk) begin
        if (alloc_en) begin
            ent_addr[free_slot] <= alloc_addr;
            ent_pid[free_slot]  <= alloc_pid;
            ent_who[free_slot]  <= alloc_who;
        end
    end

    // R4
    no_alloc_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> !full);
    // R9
    free_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        free_en |-> look_hit);
    // R9
    free_makes_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (free_en && !alloc_en) |=> !full);
endmodule

// File: rtl/duo_line_fetch.sv
// Two-chip cache-line read merger with tag-matched, process-based fan-out.
// Requests from two chips are merged by an alternating-turn arbiter onto one
// memory channel and recorded in a pending table. Response beats are matched
// by address and process identifier. Each beat is offered to every chip whose
// roster holds the identifier, and always to the chip that asked for the line.
// A beat retires once all of its target chips have accepted it.
// Assumes the memory side holds a response beat stable until rsp_ready.
module duo_line_fetch
    import duo_pkg::*;
#(
    parameter int AW           = 32,
    parameter int PW           = 8,
    parameter int DW           = 256,
    parameter int OUTSTANDING  = 16,
    parameter int ROSTER_DEPTH = 8,
    parameter int RIW          = (ROSTER_DEPTH > 1) ? $clog2(ROSTER_DEPTH) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [CHIPS-1:0]           req_valid,
    output logic [CHIPS-1:0]           req_ready,
    input  logic [CHIPS-1:0][AW-1:0]   req_addr,
    input  logic [CHIPS-1:0][PW-1:0]   req_pid,
    output logic                       mem_req_valid,
    input  logic                       mem_req_ready,
    output logic [AW-1:0]              mem_req_addr,
    output logic [PW-1:0]              mem_req_pid,
    input  logic                       rsp_valid,
    output logic                       rsp_ready,
    input  logic [AW-1:0]              rsp_addr,
    input  logic [PW-1:0]              rsp_pid,
    input  logic [DW-1:0]              rsp_data,
    input  logic                       rsp_last,
    output logic [CHIPS-1:0]           dlv_valid,
    input  logic [CHIPS-1:0]           dlv_ready,
    output logic [DW-1:0]              dlv_data,
    output logic [AW-1:0]              dlv_addr,
    output logic [PW-1:0]              dlv_pid,
    output logic                       dlv_last,
    input  logic                       cfg_we,
    input  logic                       cfg_chip,
    input  logic [RIW-1:0]             cfg_idx,
    input  logic [PW-1:0]              cfg_pid,
    input  logic                       cfg_set,
    output logic                       tag_err
);
    logic       full, pick, any, hit, hit_who, retire, err_q;
    chip_mask_t grant, roster_hit, target, done_q;

    turn_arbiter u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .want  (req_valid),
        .go    (mem_req_ready && !full),
        .grant (grant),
        .pick  (pick),
        .any   (any)
    );

    // merged request channel follows the arbiter's pick
    always_comb begin
        mem_req_valid = any && !full;
        mem_req_addr  = req_addr[pick];
        mem_req_pid   = req_pid[pick];
        req_ready     = grant;
    end

    pending_table #(.AW(AW), .PW(PW), .DEPTH(OUTSTANDING)) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_en   (|grant),
        .alloc_addr (mem_req_addr),
        .alloc_pid  (mem_req_pid),
        .alloc_who  (pick),
        .full       (full),
        .look_addr  (rsp_addr),
        .look_pid   (rsp_pid),
        .look_hit   (hit),
        .look_who   (hit_who),
        .free_en    (retire && rsp_last && hit)
    );

    // one roster per chip; delivery target is roster hit or original requester
    for (genvar c = 0; c < CHIPS; c++) begin : g_chip
        pid_roster #(.PW(PW), .DEPTH(ROSTER_DEPTH), .IW(RIW)) u_ros (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (cfg_we && (cfg_chip == 1'(c))),
            .wr_idx (cfg_idx),
            .wr_pid (cfg_pid),
            .wr_set (cfg_set),
            .q_pid  (rsp_pid),
            .q_hit  (roster_hit[c])
        );
        assign target[c] = roster_hit[c] || (hit_who == 1'(c));
    end

    // fan-out valids and retire condition for the current beat
    always_comb begin
        dlv_valid = (rsp_valid && hit) ? (target & ~done_q) : '0;
        rsp_ready = !hit || ((target & ~(done_q | dlv_ready)) == '0);
        retire    = rsp_valid && rsp_ready;
        dlv_data  = rsp_data;
        dlv_addr  = rsp_addr;
        dlv_pid   = rsp_pid;
        dlv_last  = rsp_last;
    end

    // remember which chips already took the current beat
    always_ff @(posedge clk) begin
        if (!rst_n)      done_q <= '0;
        else if (retire) done_q <= '0;
        else             done_q <= done_q | (dlv_valid & dlv_ready);
    end

    // sticky flag for beats that match no pending line
    always_ff @(posedge clk) begin
        if (!rst_n)                 err_q <= 1'b0;
        else if (rsp_valid && !hit) err_q <= 1'b1;
    end

    assign tag_err = err_q;

    // R4
    full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (!mem_req_valid && req_ready == '0));
    // R3
    accept_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |-> (req_ready != '0));
    // R7
    requester_served_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && hit) |-> (dlv_valid[hit_who] || done_q[hit_who]));
    // R8
    retire_all_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ready && hit) |-> ((dlv_valid & ~dlv_ready) == '0));
    // R10
    drop_unmatched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !hit) |-> (rsp_ready && dlv_valid == '0));
    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tag_err |=> tag_err);
endmodule

// File: tb/sim_duo_line_fetch.sv
// Bench for duo_line_fetch: a behavioural reference model (queue of pending
// lines, integer turn, roster arrays) compared with the ports every clock.
module sim_duo_line_fetch;
    localparam int AW = 16, PW = 4, DW = 32, OUT = 4, ROS = 2, RIW = 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [1:0] req_valid = '0, req_ready;
    logic [1:0][AW-1:0] req_addr = '0;
    logic [1:0][PW-1:0] req_pid = '0;
    logic mem_req_valid, mem_req_ready = 1'b1;
    logic [AW-1:0] mem_req_addr;
    logic [PW-1:0] mem_req_pid;
    logic rsp_valid = 1'b0, rsp_ready, rsp_last = 1'b0;
    logic [AW-1:0] rsp_addr = '0;
    logic [PW-1:0] rsp_pid = '0;
    logic [DW-1:0] rsp_data = '0;
    logic [1:0] dlv_valid, dlv_ready = 2'b11;
    logic [DW-1:0] dlv_data;
    logic [AW-1:0] dlv_addr;
    logic [PW-1:0] dlv_pid;
    logic dlv_last;
    logic cfg_we = 1'b0, cfg_chip = 1'b0, cfg_set = 1'b0;
    logic [RIW-1:0] cfg_idx = '0;
    logic [PW-1:0] cfg_pid = '0;
    logic tag_err;

    always #5 clk = ~clk;

    duo_line_fetch #(.AW(AW), .PW(PW), .DW(DW), .OUTSTANDING(OUT),
                     .ROSTER_DEPTH(ROS), .RIW(RIW)) u0 (.*);

    typedef struct { int addr; int pid; int who; } pend_t;
    pend_t pq[$];
    int mturn = 0, cyc = 0, n_chk = 0, n_fail = 0;
    bit merr = 0, rmode = 0, ret = 0, ended = 0;
    bit [1:0] mdone = 0, acc = 0, seen = 0;
    bit rv[2][ROS];
    int rp[2][ROS];
    string phase = "R12 reset";

    task automatic chk(string r, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s (%s): actual %0h expected %0h", r, what, phase, act, exp);
        end
    endtask

    function automatic bit ros_has(int c, int p);
        for (int i = 0; i < ROS; i++) if (rv[c][i] && rp[c][i] == p) return 1;
        return 0;
    endfunction

    // one clock: compare against the model, then advance the model
    task automatic tick();
        int win, hi;
        bit full, emv, ers;
        bit [1:0] er, mask, edv;
        string tg;
        cyc++;
        if (rmode) dlv_ready = {1'(cyc % 3 != 0), 1'(cyc % 2 == 0)};
        else       dlv_ready = 2'b11;
        #2;
        full = (pq.size() == OUT);
        win = -1;
        if (req_valid[mturn]) win = mturn;
        else if (req_valid[1-mturn]) win = 1 - mturn;
        emv = (win >= 0) && !full;
        er = 0;
        if (emv && mem_req_ready) er[win] = 1'b1;
        tg = full ? "R4" : ((req_valid == 2'b11) ? "R1" : "R2");
        chk(tg, "req_ready", req_ready, er);
        chk(full ? "R4" : "R3", "mem_req_valid", mem_req_valid, emv);
        if (emv) begin
            chk("R3", "mem_req_addr", mem_req_addr, req_addr[win]);
            chk("R3", "mem_req_pid", mem_req_pid, req_pid[win]);
        end
        hi = -1;
        foreach (pq[i]) if (hi < 0 && pq[i].addr == rsp_addr && pq[i].pid == rsp_pid) hi = i;
        mask = 0;
        if (hi >= 0) for (int c = 0; c < 2; c++) mask[c] = ros_has(c, rsp_pid) || pq[hi].who == c;
        edv = (rsp_valid && hi >= 0) ? (mask & ~mdone) : 2'b00;
        ers = (hi < 0) || ((mask & ~(mdone | dlv_ready)) == 0);
        tg = (hi >= 0 && !ros_has(pq[hi].who, rsp_pid)) ? "R7" : "R6";
        chk(tg, "dlv_valid", dlv_valid, edv);
        if (rsp_valid) chk((hi < 0) ? "R10" : "R8", "rsp_ready", rsp_ready, ers);
        if (edv != 0) begin
            chk("R5", "dlv_data", dlv_data, rsp_data);
            chk("R5", "dlv_addr", dlv_addr, rsp_addr);
        end
        chk("R10", "tag_err", tag_err, merr);
        seen |= dlv_valid;
        acc = er;
        if (rsp_valid && ers) begin
            ret = 1; mdone = 0;
            if (hi < 0) merr = 1;
            else if (rsp_last) pq.delete(hi);
        end else begin
            ret = 0; mdone |= edv & dlv_ready;
        end
        if (er != 0) begin
            pq.push_back('{int'(req_addr[win]), int'(req_pid[win]), win});
            mturn = 1 - win;
        end
        if (cfg_we) begin
            rv[cfg_chip][cfg_idx] = cfg_set;
            if (cfg_set) rp[cfg_chip][cfg_idx] = int'(cfg_pid);
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cfg(bit chip, int idx, int pid, bit set);
        cfg_we = 1; cfg_chip = chip; cfg_idx = RIW'(idx); cfg_pid = PW'(pid); cfg_set = set;
        tick();
        cfg_we = 0;
    endtask

    task automatic issue(bit [1:0] who, int a0, int p0, int a1, int p1, output int first);
        bit [1:0] left = who;
        first = -1;
        req_addr[0] = AW'(a0); req_pid[0] = PW'(p0);
        req_addr[1] = AW'(a1); req_pid[1] = PW'(p1);
        req_valid = left;
        while (left != 0) begin
            tick();
            if (acc != 0 && first < 0) first = acc[1] ? 1 : 0;
            left &= ~acc;
            req_valid = left;
        end
    endtask

    task automatic send_line(int a, int p, int beats);
        seen = 0;
        for (int b = 0; b < beats; b++) begin
            rsp_valid = 1; rsp_addr = AW'(a); rsp_pid = PW'(p);
            rsp_data = DW'(a * 16 + b); rsp_last = (b == beats - 1);
            do tick(); while (!ret);
        end
        rsp_valid = 0; rsp_last = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            n_fail++;
            $display("FAIL all requirements: watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int f, s;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #2;
        chk("R12", "req_ready after reset", req_ready, 0);
        chk("R12", "mem_req_valid after reset", mem_req_valid, 0);
        chk("R12", "dlv_valid after reset", dlv_valid, 0);
        chk("R12", "tag_err after reset", tag_err, 0);
        @(negedge clk);

        phase = "R11 roster set";
        cfg(0, 0, 3, 1); cfg(1, 0, 3, 1); cfg(1, 1, 5, 1); cfg(0, 1, 7, 1);

        phase = "R1 contested alternation";
        issue(2'b11, 'h100, 3, 'h200, 3, f);
        chk("R1", "first winner after reset", f, 0);
        issue(2'b11, 'h104, 3, 'h204, 5, f);

        phase = "R4 table full";
        req_addr[0] = 'h108; req_addr[1] = 'h208; req_valid = 2'b11;
        repeat (3) tick();
        chk("R4", "pending count", pq.size(), OUT);
        req_valid = 0;

        phase = "R5 out of order";
        rmode = 1;
        send_line('h204, 5, 2);
        chk("R6", "only chip1 for pid5", seen, 2'b10);
        send_line('h100, 3, 2);
        chk("R6", "both chips for pid3", seen, 2'b11);
        send_line('h200, 3, 1);
        send_line('h104, 3, 3);
        chk("R9", "all freed", pq.size(), 0);

        phase = "R2 skipped turn";
        s = mturn;
        if (s == 0) issue(2'b10, 0, 0, 'h300, 7, f);
        else        issue(2'b01, 'h300, 7, 0, 0, f);
        issue(2'b11, 'h310, 7, 'h320, 9, f);
        chk("R2", "skipper wins next contested slot", f, s);

        phase = "R7 requester only";
        send_line('h320, 9, 2);
        chk("R7", "unregistered requester served", seen, 2'b10);
        send_line('h310, 7, 2);
        chk("R6", "pid7 to chip0 only", seen, 2'b01);
        send_line('h300, 7, 1);

        phase = "R3 downstream stall";
        mem_req_ready = 0;
        req_addr[0] = 'h500; req_pid[0] = 3; req_valid = 2'b01;
        repeat (4) tick();
        chk("R3", "no accept while stalled", pq.size(), 0);
        mem_req_ready = 1;
        issue(2'b01, 'h500, 3, 0, 0, f);

        phase = "R11 roster clear";
        cfg(1, 0, 0, 0);
        send_line('h500, 3, 2);
        chk("R11", "cleared chip excluded", seen, 2'b01);

        phase = "R9 stale beat";
        rmode = 0;
        send_line('h500, 3, 1);
        tick();
        chk("R9", "stale beat flagged", tag_err, 1);

        phase = "R10 unmatched beat";
        send_line('hBEE, 1, 1);
        chk("R10", "unmatched not delivered", seen, 0);
        tick();
        chk("R10", "flag stays set", tag_err, 1);

        ended = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule